// File: doc/BRIEF.md
# Programmable Down-Counter Timer Core

This block is one timer channel behind a small word-addressed register interface. A down-counter advances once per prescaled tick, derived from a clock-enable input divided by 1, 16 or 256. When the count is zero at a tick, the counter expires. The counter then reloads and sets a raw interrupt flag. The interrupt output is that flag gated by an interrupt-enable bit in the control register.

Software picks one of three modes. Free-running wraps to the full-scale count. Periodic reloads from a stored limit. One-shot stops at zero after a single expiry. A control bit picks either a 16-bit or a 32-bit counter. The limit can be written in two ways: an immediate write reloads the counter at once, and a deferred write only changes the value used at the next reload. Status can be read in raw form or in masked form, and an interrupt-clear location clears the flag.

Top module: `dtm_timer_core`

## Requirements
- R1: After reset the control register reads 0x20 (interrupt enable set, counting disabled). The value register reads 0x0000FFFF. The load, raw and masked status registers read 0, and `irq` is 0.
- R2: Control bit 7 enables counting. Control bits 3:2 select the prescaler: 00 divides by 1, 01 by 16, 10 by 256, and 11 divides by 1. One prescaled tick occurs every N cycles that have `tick_en` high while counting is enabled. Cycles with `tick_en` low do not advance the count. Any write to the control register (offset 2) restarts the prescaler phase.
- R3: A write to offset 0 stores the limit and, outside free-running mode, loads it into the counter on the same edge. Offsets 0 and 6 both read back the stored limit.
- R4: A write to offset 6 stores the limit without touching the counter. The new value is used at the next reload.
- R5: Periodic mode is control bit 6 set with bit 0 clear. At a tick with the count at zero, the counter reloads from the limit and the raw flag is set. Otherwise a tick decrements the count by one.
- R6: Free-running mode is control bits 6 and 0 both clear. At expiry the counter reloads to 0xFFFF in 16-bit mode (control bit 1 clear) or 0xFFFFFFFF in 32-bit mode (bit 1 set). A load write in this mode also sets the counter to full scale. In 16-bit mode only the low half counts, and offset 1 reads it zero-extended.
- R7: One-shot mode is control bit 0 set. After one expiry the count stays at zero and raises no further interrupt until the next load write or control write.
- R8: Offset 4 bit 0 reads the raw flag. Offset 5 bit 0 reads the raw flag ANDed with control bit 5. `irq` equals the masked value.
- R9: Any write to offset 3 clears the raw flag. If an expiry occurs in the same cycle, the expiry wins and the flag stays set.
- R10: Writes to offset 1 and offset 7 change nothing. Reads of offsets 3 and 7 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Clock enable feeding the prescaler |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register word offset |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| irq | output | 1 | Masked interrupt |

## Verification
On every cycle, assertions check four behaviours: the prescaler phase restarts after a control write, an unticked counter holds its value, an immediate load lands on the next edge, and free-running expiry wraps to full scale. They also check that a halted one-shot counter stays still and that the raw flag responds to expiry and clearing. Several outcomes are visible only through the bench's scenarios: the exact tick spacing for each prescaler setting, a deferred limit taking effect only at the following wrap, and the masked and raw readback agreeing under random mode changes.

// File: rtl/dtm_pkg.sv
package dtm_pkg;
  localparam int REG_W   = 32;
  localparam int CTRL_W  = 8;
  localparam int PHASE_W = 8;
  localparam int HALF_W  = REG_W / 2;

  typedef enum logic [2:0] {
    OFF_LOAD   = 3'd0,
    OFF_VALUE  = 3'd1,
    OFF_CTRL   = 3'd2,
    OFF_ICLR   = 3'd3,
    OFF_RAW    = 3'd4,
    OFF_MSK    = 3'd5,
    OFF_BGLOAD = 3'd6
  } reg_off_e;

  localparam int CB_ONESHOT  = 0;
  localparam int CB_WIDE     = 1;
  localparam int CB_PSC_LO   = 2;
  localparam int CB_IE       = 5;
  localparam int CB_PERIODIC = 6;
  localparam int CB_RUN      = 7;

  localparam logic [CTRL_W-1:0] CTRL_RESET = 8'h20;

  function automatic logic [PHASE_W-1:0] psc_last(input logic [1:0] sel);
    case (sel)
      2'b01:   psc_last = PHASE_W'(15);
      2'b10:   psc_last = PHASE_W'(255);
      default: psc_last = '0;
    endcase
  endfunction

  function automatic logic [REG_W-1:0] wrap_max(input logic wide);
    wrap_max = wide ? {REG_W{1'b1}} : {{HALF_W{1'b0}}, {HALF_W{1'b1}}};
  endfunction

  function automatic logic [REG_W-1:0] count_view(input logic [REG_W-1:0] c, input logic wide);
    count_view = wide ? c : {{HALF_W{1'b0}}, c[HALF_W-1:0]};
  endfunction

  function automatic logic [REG_W-1:0] step_down(input logic [REG_W-1:0] c, input logic wide);
    logic [HALF_W-1:0] lo;
    lo = c[HALF_W-1:0] - HALF_W'(1);
    step_down = wide ? (c - REG_W'(1)) : {c[REG_W-1:HALF_W], lo};
  endfunction
endpackage

// File: rtl/dtm_prescaler.sv
module dtm_prescaler
  import dtm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic       tick_en,
  input  logic [1:0] sel,
  input  logic       restart,
  output logic       ptick
);
  logic [PHASE_W-1:0] phase;
  logic               at_last;

  always_comb begin
    at_last = (phase == psc_last(sel));
    ptick   = run & tick_en & at_last;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)               phase <= '0;
    else if (restart)         phase <= '0;
    else if (run && tick_en)  phase <= at_last ? '0 : phase + PHASE_W'(1);
  end

  AST_PHASE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (phase == '0)); // R2
endmodule

// File: rtl/dtm_counter.sv
module dtm_counter
  import dtm_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ptick,
  input  logic             load_wr,
  input  logic             ctrl_wr,
  input  logic [REG_W-1:0] wdata,
  input  logic [REG_W-1:0] limit,
  input  logic             wide,
  input  logic             free,
  input  logic             oneshot,
  output logic [REG_W-1:0] cnt_view,
  output logic             expire
);
  logic [REG_W-1:0] cnt;
  logic             done;
  logic             at_zero;

  always_comb begin
    cnt_view = count_view(cnt, wide);
    at_zero  = (cnt_view == '0);
    expire   = ptick & ~done & at_zero & ~load_wr;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt  <= {REG_W{1'b1}};
      done <= 1'b0;
    end else begin
      if (load_wr) begin
        cnt <= free ? wrap_max(wide) : wdata;
      end else if (ptick && !done) begin
        if (!at_zero)      cnt <= step_down(cnt, wide);
        else if (!oneshot) cnt <= free ? wrap_max(wide) : limit;
      end
      if (load_wr || ctrl_wr)      done <= 1'b0;
      else if (expire && oneshot)  done <= 1'b1;
    end
  end

  AST_LOAD_IMMEDIATE: assert property (@(posedge clk) disable iff (!rst_n)
    (load_wr && !free) |=> (cnt == $past(wdata))); // R3
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!ptick && !load_wr) |=> $stable(cnt)); // R2
  AST_FREE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && free) |=> (cnt == wrap_max($past(wide)))); // R6
  AST_ONESHOT_HALT: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !load_wr) |=> $stable(cnt)); // R7
endmodule

// File: rtl/dtm_regs.sv
module dtm_regs
  import dtm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [2:0]        addr,
  input  logic [REG_W-1:0]  wdata,
  input  logic              expire,
  input  logic [REG_W-1:0]  cnt_view,
  output logic [CTRL_W-1:0] ctrl,
  output logic [REG_W-1:0]  limit,
  output logic              raw,
  output logic              load_wr,
  output logic              ctrl_wr,
  output logic [REG_W-1:0]  rdata
);
  logic bg_wr, clr_wr;

  always_comb begin
    load_wr = wr_en && (addr == OFF_LOAD);
    ctrl_wr = wr_en && (addr == OFF_CTRL);
    bg_wr   = wr_en && (addr == OFF_BGLOAD);
    clr_wr  = wr_en && (addr == OFF_ICLR);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl  <= CTRL_RESET;
      limit <= '0;
      raw   <= 1'b0;
    end else begin
      if (ctrl_wr)              ctrl  <= wdata[CTRL_W-1:0];
      if (load_wr || bg_wr)     limit <= wdata;
      if (expire)               raw   <= 1'b1;
      else if (clr_wr)          raw   <= 1'b0;
    end
  end

  always_comb begin
    case (addr)
      OFF_LOAD, OFF_BGLOAD: rdata = limit;
      OFF_VALUE:            rdata = cnt_view;
      OFF_CTRL:             rdata = {{(REG_W-CTRL_W){1'b0}}, ctrl};
      OFF_RAW:              rdata = {{(REG_W-1){1'b0}}, raw};
      OFF_MSK:              rdata = {{(REG_W-1){1'b0}}, raw & ctrl[CB_IE]};
      default:              rdata = '0;
    endcase
  end

  AST_RAW_SET: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> raw); // R5
  AST_RAW_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wr && !expire) |=> !raw); // R9
endmodule

// File: rtl/dtm_timer_core.sv
module dtm_timer_core
  import dtm_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             wr_en,
  input  logic [2:0]       addr,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] rdata,
  output logic             irq
);
  logic [CTRL_W-1:0] ctrl;
  logic [REG_W-1:0]  limit, cnt_view;
  logic              raw, load_wr, ctrl_wr, ptick, expire;
  logic              wide, free, oneshot;

  always_comb begin
    wide    = ctrl[CB_WIDE];
    oneshot = ctrl[CB_ONESHOT];
    free    = ~ctrl[CB_PERIODIC] & ~ctrl[CB_ONESHOT];
    irq     = raw & ctrl[CB_IE];
  end

  dtm_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .expire(expire), .cnt_view(cnt_view), .ctrl(ctrl), .limit(limit),
    .raw(raw), .load_wr(load_wr), .ctrl_wr(ctrl_wr), .rdata(rdata)
  );

  dtm_prescaler u_psc (
    .clk(clk), .rst_n(rst_n), .run(ctrl[CB_RUN]), .tick_en(tick_en),
    .sel(ctrl[CB_PSC_LO+1:CB_PSC_LO]), .restart(ctrl_wr), .ptick(ptick)
  );

  dtm_counter u_cnt (
    .clk(clk), .rst_n(rst_n), .ptick(ptick), .load_wr(load_wr),
    .ctrl_wr(ctrl_wr), .wdata(wdata), .limit(limit), .wide(wide),
    .free(free), .oneshot(oneshot), .cnt_view(cnt_view), .expire(expire)
  );

  AST_TICK_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    ptick |-> (ctrl[CB_RUN] && tick_en)); // R2
endmodule

// File: tb/dtm_timer_core_tb.sv
module dtm_timer_core_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  addr = 3'd0;
  logic [31:0] wdata = 32'd0;
  logic [31:0] rdata;
  logic        irq;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  // reference state
  logic [7:0]  m_ctrl;
  logic [31:0] m_lim, m_cnt;
  logic        m_raw, m_done;
  int          m_phase;

  always #(CLK_PERIOD/2) clk = ~clk;

  dtm_timer_core dut_i (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  function automatic int divisor(input logic [1:0] s);
    return (s == 2'd3) ? 1 : (1 << (4 * s));
  endfunction

  function automatic logic [31:0] full_scale(input logic w32);
    return w32 ? 32'hFFFF_FFFF : 32'h0000_FFFF;
  endfunction

  function automatic logic [31:0] seen(input logic [31:0] c, input logic w32);
    return w32 ? c : (c & 32'h0000_FFFF);
  endfunction

  function automatic logic [31:0] m_read(input logic [2:0] a);
    case (a)
      3'd0, 3'd6: return m_lim;
      3'd1:       return seen(m_cnt, m_ctrl[1]);
      3'd2:       return {24'd0, m_ctrl};
      3'd4:       return {31'd0, m_raw};
      3'd5:       return {31'd0, m_raw && m_ctrl[5]};
      default:    return 32'd0;
    endcase
  endfunction

  task automatic m_reset();
    m_ctrl = 8'h20; m_lim = 0; m_cnt = 32'hFFFF_FFFF;
    m_raw = 0; m_done = 0; m_phase = 0;
  endtask

  task automatic m_step(input bit we, input logic [2:0] a, input logic [31:0] d, input bit te);
    bit run, tk, w32, fr, os, ldw, cw, bw, clw, exp_ev, zero;
    int dv;
    run = m_ctrl[7]; w32 = m_ctrl[1]; os = m_ctrl[0];
    fr  = !m_ctrl[6] && !m_ctrl[0];
    dv  = divisor(m_ctrl[3:2]);
    tk  = run && te && (m_phase == dv - 1);
    ldw = we && a == 3'd0; cw = we && a == 3'd2;
    bw  = we && a == 3'd6; clw = we && a == 3'd3;
    zero = (seen(m_cnt, w32) == 0);
    exp_ev = tk && !m_done && zero && !ldw;
    if (ldw) m_cnt = fr ? full_scale(w32) : d;
    else if (tk && !m_done) begin
      if (!zero) m_cnt = w32 ? m_cnt - 1 : ((m_cnt & 32'hFFFF_0000) | ((m_cnt - 1) & 32'h0000_FFFF));
      else if (!os) m_cnt = fr ? full_scale(w32) : m_lim;
    end
    if (ldw || cw) m_done = 0; else if (exp_ev && os) m_done = 1;
    if (cw) m_phase = 0;
    else if (run && te) m_phase = (m_phase == dv - 1) ? 0 : m_phase + 1;
    if (ldw || bw) m_lim = d;
    if (cw) m_ctrl = d[7:0];
    if (exp_ev) m_raw = 1; else if (clw) m_raw = 0;
  endtask

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", tag, got, exp);
    end
  endtask

  // one clock cycle; returns at the following falling edge
  task automatic drive(input bit we, input logic [2:0] a, input logic [31:0] d, input bit te);
    wr_en = we; addr = a; wdata = d; tick_en = te;
    m_step(we, a, d, te);
    @(posedge clk);
    @(negedge clk);
    wr_en = 0; tick_en = 0;
  endtask

  task automatic rd(input string tag, input logic [2:0] a, input logic [31:0] exp);
    addr = a; wr_en = 0;
    #1;
    chk(tag, rdata, exp);
  endtask

  task automatic run_ticks(input int n, input bit te);
    for (int i = 0; i < n; i++) drive(0, 3'd1, 0, te);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
  endtask

  initial begin
    for (int c = 0; c < 190000; c++) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    int unsigned seed_sink;
    seed_sink = $urandom(32'd20240611);
    m_reset();
    @(negedge clk); @(negedge clk);
    rst_n = 1;

    // R1 reset state
    rd("R1 ctrl", 3'd2, 32'h20);
    rd("R1 value", 3'd1, 32'h0000_FFFF);
    rd("R1 load", 3'd0, 32'h0);
    rd("R1 raw", 3'd4, 32'h0);
    rd("R1 masked", 3'd5, 32'h0);
    chk("R1 irq", {31'd0, irq}, 32'd0);

    // R3 immediate load while disabled (ctrl 0x20 has bit0=0,bit6=0: free) -> set periodic first
    drive(1, 3'd2, 32'h62, 0);
    drive(1, 3'd0, 32'd5, 0);
    rd("R3 value", 3'd1, 32'd5);
    rd("R3 load rd", 3'd0, 32'd5);
    rd("R3 bgload rd", 3'd6, 32'd5);

    // R5 periodic, 32-bit, div1, ie
    drive(1, 3'd2, 32'hE2, 0);
    run_ticks(5, 1);
    rd("R5 at zero", 3'd1, 32'd0);
    rd("R5 raw before", 3'd4, 32'd0);
    run_ticks(1, 1);
    rd("R5 reload", 3'd1, 32'd5);
    rd("R5 raw set", 3'd4, 32'd1);
    rd("R8 masked", 3'd5, 32'd1);
    chk("R8 irq high", {31'd0, irq}, 32'd1);

    // R9 clear
    drive(1, 3'd3, 32'hDEAD_BEEF, 0);
    rd("R9 raw clr", 3'd4, 32'd0);
    chk("R9 irq low", {31'd0, irq}, 32'd0);

    // R4 deferred limit
    drive(1, 3'd6, 32'd2, 0);
    rd("R4 value kept", 3'd1, 32'd5);
    rd("R4 limit", 3'd0, 32'd2);
    run_ticks(6, 1);
    rd("R4 next reload", 3'd1, 32'd2);
    drive(1, 3'd3, 0, 0);

    // R8 masking with ie off
    drive(1, 3'd2, 32'hC2, 0);
    run_ticks(3, 1);
    rd("R8 raw", 3'd4, 32'd1);
    rd("R8 masked off", 3'd5, 32'd0);
    chk("R8 irq masked", {31'd0, irq}, 32'd0);
    drive(1, 3'd2, 32'hE2, 0);
    chk("R8 irq unmasked", {31'd0, irq}, 32'd1);
    drive(1, 3'd3, 0, 0);

    // R7 one-shot
    drive(1, 3'd0, 32'd2, 0);
    drive(1, 3'd2, 32'hA3, 0);
    run_ticks(3, 1);
    rd("R7 expired", 3'd1, 32'd0);
    rd("R7 raw", 3'd4, 32'd1);
    drive(1, 3'd3, 0, 0);
    run_ticks(4, 1);
    rd("R7 halted", 3'd1, 32'd0);
    rd("R7 no reraise", 3'd4, 32'd0);

    // R6 free-running 16-bit wrap and zero extension
    drive(1, 3'd2, 32'h62, 0);
    drive(1, 3'd0, 32'h0001_0001, 0);
    drive(1, 3'd2, 32'hA0, 0);
    rd("R6 zero-ext", 3'd1, 32'h0000_0001);
    run_ticks(1, 1);
    rd("R6 low zero", 3'd1, 32'd0);
    run_ticks(1, 1);
    rd("R6 wrap 16", 3'd1, 32'h0000_FFFF);
    rd("R6 raw", 3'd4, 32'd1);
    drive(1, 3'd0, 32'd9, 0);
    rd("R6 load ignored", 3'd1, 32'h0000_FFFF);
    drive(1, 3'd3, 0, 0);

    // R2 prescaler
    drive(1, 3'd2, 32'h62, 0);
    drive(1, 3'd0, 32'd3, 0);
    drive(1, 3'd2, 32'hE6, 0);
    run_ticks(15, 1);
    rd("R2 div16 hold", 3'd1, 32'd3);
    run_ticks(1, 1);
    rd("R2 div16 step", 3'd1, 32'd2);
    drive(1, 3'd2, 32'hEA, 0);
    run_ticks(255, 1);
    rd("R2 div256 hold", 3'd1, 32'd2);
    run_ticks(1, 1);
    rd("R2 div256 step", 3'd1, 32'd1);
    run_ticks(300, 0);
    rd("R2 gated", 3'd1, 32'd1);

    // R10 ignored writes, undefined reads
    drive(1, 3'd1, 32'h55, 0);
    rd("R10 value write", 3'd1, 32'd1);
    drive(1, 3'd7, 32'hFFFF_FFFF, 0);
    rd("R10 ctrl kept", 3'd2, 32'hEA);
    rd("R10 read 7", 3'd7, 32'd0);
    rd("R10 read 3", 3'd3, 32'd0);

    // constrained random, checked against the reference every cycle
    for (int i = 0; i < 6000; i++) begin
      int op;
      logic [2:0]  a;
      logic [31:0] d;
      bit we, te;
      op = $urandom_range(0, 99);
      te = ($urandom_range(0, 9) < 7);
      we = 1; d = 0;
      if (op < 55)      begin we = 0; a = 3'($urandom_range(0, 7)); end
      else if (op < 63) begin a = 3'd2; d = {24'd0, 8'($urandom) & 8'hEF}; d[7] = 1'b1; if ($urandom_range(0,3)==0) d[3:2] = 2'b01; else d[3:2] = 2'b00; end
      else if (op < 72) begin a = 3'd0; d = ($urandom_range(0,4)==0) ? {16'($urandom), 16'($urandom_range(0, 30))} : 32'($urandom_range(0, 30)); end
      else if (op < 80) begin a = 3'd6; d = 32'($urandom_range(0, 30)); end
      else if (op < 92) begin a = 3'd3; d = $urandom; end
      else              begin a = ($urandom_range(0,1) == 0) ? 3'd1 : 3'd7; d = $urandom; end
      drive(we, a, d, te);
      a = 3'($urandom_range(0, 7));
      rd((a == 3'd1) ? "R5 rnd value" : (a == 3'd4 || a == 3'd5) ? "R8 rnd status" :
         (a == 3'd0 || a == 3'd6) ? "R3 rnd limit" : (a == 3'd2) ? "R2 rnd ctrl" : "R10 rnd undef",
         a, m_read(a));
      chk("R8 rnd irq", {31'd0, irq}, {31'd0, m_raw && m_ctrl[5]});
    end

    finished = 1;
    summary();
    $finish;
  end
endmodule